// File: doc/BRIEF.md
# Switchable-Carrier Binary FSK Demodulator

This block recovers a bit stream from a sampled binary frequency-shift-keyed signal. Each accepted 12-bit signed sample is multiplied by a local sine carrier from an internal numerically controlled oscillator. The full-precision product is smoothed by a first-order recursive low-pass filter and then averaged over its last 16 values. A registered threshold slicer turns the averaged level into one recovered bit per sample.

The oscillator sits on the lower (space) tone of the selected channel. A space tone therefore yields a large positive level, and the slicer inverts the polarity: a level above the threshold gives 0 and a level at or below it gives 1 (mark). The two channel presets are parameters. At an assumed 4 kHz sample rate, preset 0 targets the 968 Hz / 1031 Hz pair and preset 1 a space tone at 1500 Hz.

Flipping the carrier select while the block runs retunes the oscillator and restarts the datapath from a clean state. This lets the block follow a transmitter that changes carrier.

Top module: `fsk_demod`

## Requirements
- R1: While `rst_ni` is low and directly after it is released, `bit_valid_o` and `bit_o` are 0.
- R2: The oscillator is a 24-bit phase accumulator. It starts at phase 0 and advances by the selected preset increment once per accepted sample. Its top 8 bits index a 256-entry signed sine table of amplitude 2047. The defaults are 4060086 for preset 0 (968 Hz at 4 kHz) and 6291456 for preset 1 (1500 Hz at 4 kHz).
- R3: The product of sample and sine is kept at 24 bits. The loop filter applies y <= y + ((x - y) >>> 5), and its state never leaves the 24-bit signed range.
- R4: The averaged level is the 16-value sum of loop-filter outputs shifted right arithmetically by 4.
- R5: The slicer outputs 0 when the signed 24-bit level is greater than the signed 24-bit `thresh_i`, and 1 otherwise.
- R6: A sample accepted on a rising edge (with `smp_valid_i` high) produces its `bit_valid_o` pulse of one cycle after the fourth rising edge that follows. This happens only when the averager is full, and there is no more than one pulse per sample.
- R7: After reset or a restart, the first 15 accepted samples give no `bit_valid_o` pulse. The 16th and every later sample give one.
- R8: A change of `carrier_sel_i` restarts the block. Oscillator phase, loop-filter state, averager history and fill count are zeroed, in-flight results are dropped, and a sample offered in that same cycle is discarded. With zero input, the level afterwards is exactly 0.
- R9: With threshold 920000 and a tone of amplitude 1800 that starts in phase with the restarted oscillator, the behaviour after settling is as follows. On preset 0, a 968 Hz tone decodes as 0 and a 1031 Hz tone as 1. On preset 1, a 1500 Hz tone decodes as 0 and a 968 Hz tone as 1.
- R10: Cycles with `smp_valid_i` low change neither oscillator phase nor filter state, and produce no `bit_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 12 | Signed input sample |
| carrier_sel_i | input | 1 | Carrier preset select (0 or 1) |
| thresh_i | input | 24 | Signed slicer threshold |
| bit_valid_o | output | 1 | Recovered-bit strobe |
| bit_o | output | 1 | Recovered bit (1 = mark, 0 = space) |

## Verification
The in-line properties check several rules on every cycle:
- the loop-filter state stays inside its 24-bit range;
- idle cycles leave the phase and the running sum untouched;
- every output pulse lines up with a sample four edges earlier;
- a pulse only leaves a full averager;
- a restart silences the output for the following cycles.

Only the bench scenarios can show the rest. These cover the fill count of 15 silent samples, the inverted slicer polarity against a threshold, and the exact zero level after a carrier switch that proves the history was cleared. They also cover correct tone discrimination on both presets, which depends on the oscillator frequency, the filters and the sine table together.

// File: rtl/fsk_demod_pkg.sv
package fsk_demod_pkg;

  // Rational sine approximation over one half period, mirrored for the other half.
  function automatic int sine_entry(int idx, int depth, int amp);
    int half;
    int u;
    int p;
    int den;
    int mag;
    half = depth / 2;
    u    = idx % half;
    p    = u * (half - u);
    den  = 5 * half * half - 4 * p;
    mag  = (16 * amp * p + den / 2) / den;
    return (idx < half) ? mag : -mag;
  endfunction

endpackage

// File: rtl/fsk_nco_mixer.sv
module fsk_nco_mixer #(
  parameter int          SMP_W   = 12,
  parameter int          PHASE_W = 24,
  parameter int          LUT_AW  = 8,
  parameter int          LUT_DW  = 12,
  parameter int unsigned INC0    = 4060086,
  parameter int unsigned INC1    = 6291456,
  localparam int         PROD_W  = SMP_W + LUT_DW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     sel_i,
  input  logic                     vld_i,
  input  logic signed [SMP_W-1:0]  smp_i,
  output logic                     vld_o,
  output logic signed [PROD_W-1:0] prod_o
);
  localparam int DEPTH = 1 << LUT_AW;
  localparam int AMP   = (1 << (LUT_DW - 1)) - 1;

  logic signed [LUT_DW-1:0] lut [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_lut
    assign lut[g] = LUT_DW'(fsk_demod_pkg::sine_entry(g, DEPTH, AMP));
  end

  logic [PHASE_W-1:0]       phase_q;
  logic [PHASE_W-1:0]       inc;
  logic signed [LUT_DW-1:0] carrier;
  logic                     vld_q;
  logic signed [PROD_W-1:0] prod_q;

  assign inc     = sel_i ? PHASE_W'(INC1) : PHASE_W'(INC0);
  assign carrier = lut[phase_q[PHASE_W-1 -: LUT_AW]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      vld_q   <= 1'b0;
      prod_q  <= '0;
    end else if (flush_i) begin
      phase_q <= '0;
      vld_q   <= 1'b0;
      prod_q  <= '0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        prod_q  <= smp_i * carrier;
        phase_q <= phase_q + inc;
      end
    end
  end

  assign vld_o  = vld_q;
  assign prod_o = prod_q;

  p_phase_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !flush_i) |=> $stable(phase_q));

endmodule

// File: rtl/fsk_loop_lpf.sv
module fsk_loop_lpf #(
  parameter int W     = 24,
  parameter int SHIFT = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                vld_i,
  input  logic signed [W-1:0] x_i,
  output logic                vld_o,
  output logic signed [W-1:0] y_o
);
  // One guard bit so the difference never wraps.
  logic signed [W:0] y_q;
  logic signed [W:0] diff;
  logic signed [W:0] step;
  logic              vld_q;

  assign diff = {x_i[W-1], x_i} - y_q;
  assign step = diff >>> SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q   <= '0;
      vld_q <= 1'b0;
    end else if (flush_i) begin
      y_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) y_q <= y_q + step;
    end
  end

  assign vld_o = vld_q;
  assign y_o   = y_q[W-1:0];

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_q[W] == y_q[W-1]);

  p_state_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !flush_i) |=> $stable(y_q));

endmodule

// File: rtl/fsk_avg.sv
module fsk_avg #(
  parameter int W    = 24,
  parameter int TAPS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                vld_i,
  input  logic signed [W-1:0] x_i,
  output logic                vld_o,
  output logic signed [W-1:0] lvl_o
);
  localparam int SH    = $clog2(TAPS);
  localparam int SUM_W = W + SH;
  localparam int CNT_W = $clog2(TAPS + 1);

  logic signed [W-1:0]     hist [TAPS];
  logic signed [SUM_W-1:0] sum_q;
  logic signed [SUM_W-1:0] sum_d;
  logic [CNT_W-1:0]        fill_q;
  logic                    vld_q;

  assign sum_d = sum_q + {{SH{x_i[W-1]}}, x_i}
                       - {{SH{hist[TAPS-1][W-1]}}, hist[TAPS-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist[0] <= '0;
    end else if (flush_i) begin
      hist[0] <= '0;
    end else if (vld_i) begin
      hist[0] <= x_i;
    end
  end

  for (genvar g = 1; g < TAPS; g++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hist[g] <= '0;
      end else if (flush_i) begin
        hist[g] <= '0;
      end else if (vld_i) begin
        hist[g] <= hist[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      fill_q <= '0;
      vld_q  <= 1'b0;
    end else if (flush_i) begin
      sum_q  <= '0;
      fill_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_i && (fill_q >= CNT_W'(TAPS - 1));
      if (vld_i) begin
        sum_q <= sum_d;
        if (fill_q != CNT_W'(TAPS)) fill_q <= fill_q + 1'b1;
      end
    end
  end

  assign vld_o = vld_q;
  assign lvl_o = sum_q[SUM_W-1:SH];

  p_full_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (fill_q == CNT_W'(TAPS)));

  p_sum_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !flush_i) |=> $stable(sum_q));

endmodule

// File: rtl/fsk_demod.sv
module fsk_demod #(
  parameter int          SMP_W   = 12,
  parameter int          PHASE_W = 24,
  parameter int          LUT_AW  = 8,
  parameter int          LUT_DW  = 12,
  parameter int unsigned INC0    = 4060086,
  parameter int unsigned INC1    = 6291456,
  parameter int          LF_SH   = 5,
  parameter int          TAPS    = 16,
  localparam int         PROD_W  = SMP_W + LUT_DW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_valid_i,
  input  logic signed [SMP_W-1:0]  smp_data_i,
  input  logic                     carrier_sel_i,
  input  logic signed [PROD_W-1:0] thresh_i,
  output logic                     bit_valid_o,
  output logic                     bit_o
);
  logic                     sel_q;
  logic                     flush;
  logic                     mix_vld;
  logic signed [PROD_W-1:0] mix_prod;
  logic                     lf_vld;
  logic signed [PROD_W-1:0] lf_y;
  logic                     avg_vld;
  logic signed [PROD_W-1:0] avg_lvl;
  logic                     bit_vld_q;
  logic                     bit_q;

  assign flush = carrier_sel_i != sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= carrier_sel_i;
  end

  fsk_nco_mixer #(
    .SMP_W  (SMP_W),
    .PHASE_W(PHASE_W),
    .LUT_AW (LUT_AW),
    .LUT_DW (LUT_DW),
    .INC0   (INC0),
    .INC1   (INC1)
  ) i_mix (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush),
    .sel_i  (sel_q),
    .vld_i  (smp_valid_i),
    .smp_i  (smp_data_i),
    .vld_o  (mix_vld),
    .prod_o (mix_prod)
  );

  fsk_loop_lpf #(
    .W    (PROD_W),
    .SHIFT(LF_SH)
  ) i_lpf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush),
    .vld_i  (mix_vld),
    .x_i    (mix_prod),
    .vld_o  (lf_vld),
    .y_o    (lf_y)
  );

  fsk_avg #(
    .W   (PROD_W),
    .TAPS(TAPS)
  ) i_avg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush),
    .vld_i  (lf_vld),
    .x_i    (lf_y),
    .vld_o  (avg_vld),
    .lvl_o  (avg_lvl)
  );

  // Space tone gives the larger level, so the comparison is inverted.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_vld_q <= 1'b0;
      bit_q     <= 1'b0;
    end else if (flush) begin
      bit_vld_q <= 1'b0;
    end else begin
      bit_vld_q <= avg_vld;
      if (avg_vld) bit_q <= !(avg_lvl > thresh_i);
    end
  end

  assign bit_valid_o = bit_vld_q;
  assign bit_o       = bit_q;

  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> $past(smp_valid_i, 4));

  p_restart_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (!bit_valid_o ##1 !bit_valid_o ##1 !bit_valid_o ##1 !bit_valid_o));

endmodule

// File: tb/test_fsk_demod.sv
module test_fsk_demod;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_valid = 1'b0;
  logic signed [11:0] smp_data = '0;
  logic               csel = 1'b0;
  logic signed [23:0] thresh = '0;
  logic               bit_valid;
  logic               bit_val;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fsk_demod i_fsk_demod (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .smp_valid_i  (smp_valid),
    .smp_data_i   (smp_data),
    .carrier_sel_i(csel),
    .thresh_i     (thresh),
    .bit_valid_o  (bit_valid),
    .bit_o        (bit_val)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One isolated sample; returns the output seen after the fourth edge.
  task automatic push(input logic signed [11:0] s, output logic v, output logic b);
    logic early;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = s;
    @(negedge clk);
    smp_valid = 1'b0;
    smp_data  = '0;
    @(negedge clk);
    @(negedge clk);
    early = bit_valid;
    @(negedge clk);
    v = bit_valid;
    b = bit_val;
    if (early) chk("R6 early pulse", 1, 0);
  endtask

  task automatic restart();
    @(negedge clk);
    csel = ~csel;
    repeat (2) @(negedge clk);
    csel = ~csel;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", int'(bit_valid), 0);
    chk("R1 bit in reset", int'(bit_val), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(bit_valid), 0);
    chk("R1 bit after reset", int'(bit_val), 0);
  endtask

  task automatic t_fill();
    logic v, b;
    int early_v;
    early_v = 0;
    thresh = -24'sd1;
    for (int i = 0; i < 15; i++) begin
      push(12'sd0, v, b);
      early_v += int'(v);
    end
    chk("R7 pulses in first 15 samples", early_v, 0);
    push(12'sd0, v, b);
    chk("R7 pulse on 16th sample", int'(v), 1);
    chk("R6 pulse four edges after sample", int'(v), 1);
    chk("R5 level 0 above thresh -1 gives 0", int'(b), 0);
    thresh = 24'sd0;
    push(12'sd0, v, b);
    chk("R5 level 0 at thresh 0 gives 1", int'(b), 1);
    chk("R7 pulse on 17th sample", int'(v), 1);
  endtask

  task automatic t_idle();
    int seen;
    seen = 0;
    repeat (30) begin
      @(negedge clk);
      seen += int'(bit_valid);
    end
    chk("R10 pulses while idle", seen, 0);
  endtask

  task automatic t_tone(input logic sel, input real f, input int exp_bit, input string tag);
    logic v, b;
    int s, bad, pulses;
    bad = 0;
    pulses = 0;
    @(negedge clk);
    csel = sel;
    restart();
    thresh = 24'sd920000;
    for (int n = 0; n < 400; n++) begin
      s = int'(1800.0 * $sin(6.283185307179586 * f * real'(n) / 4000.0));
      push(12'(s), v, b);
      pulses += int'(v);
      if (n >= 300 && (!v || int'(b) != exp_bit)) bad++;
    end
    chk({tag, " mismatched bits after settling"}, bad, 0);
    chk({tag, " R6 one pulse per sample once full"}, pulses, 400 - 15);
  endtask

  task automatic t_switch();
    logic v, b;
    int s, early_v;
    early_v = 0;
    @(negedge clk);
    csel = 1'b0;
    restart();
    for (int n = 0; n < 300; n++) begin
      s = int'(1800.0 * $sin(6.283185307179586 * 968.0 * real'(n) / 4000.0));
      push(12'(s), v, b);
    end
    // Select change with a sample in the same cycle: sample must be dropped.
    @(negedge clk);
    csel      = 1'b1;
    smp_valid = 1'b1;
    smp_data  = 12'sd1500;
    @(negedge clk);
    smp_valid = 1'b0;
    smp_data  = '0;
    repeat (4) @(negedge clk);
    chk("R8 no pulse after switch", int'(bit_valid), 0);
    for (int i = 0; i < 15; i++) begin
      push(12'sd0, v, b);
      early_v += int'(v);
    end
    chk("R8 discarded sample not counted", early_v, 0);
    thresh = -24'sd1;
    push(12'sd0, v, b);
    chk("R8 pulse on 16th fresh sample", int'(v), 1);
    chk("R8 cleared level above -1", int'(b), 0);
    thresh = 24'sd0;
    push(12'sd0, v, b);
    chk("R8 cleared level not above 0", int'(b), 1);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL R6 watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_fill();
    t_idle();
    t_tone(1'b0, 968.0,  0, "R9 R2 R3 R4 preset0 space");
    t_tone(1'b0, 1031.0, 1, "R9 R2 R3 R4 preset0 mark");
    t_tone(1'b1, 1500.0, 0, "R9 R2 preset1 space");
    t_tone(1'b1, 968.0,  1, "R9 R2 preset1 other");
    t_switch();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule